// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. It starts from a root entry selected by a context base pointer and a context number, then descends through up to three table levels. A walk can end at level 1 (16 MB page), level 2 (256 KB page) or level 3 (4 KB page). On a successful walk it returns the physical address, the 3-bit permission field and the final entry. On a failed walk it returns a fault code made of the level and a type. Before it returns, it sets the referenced and modified bits of the final entry. It writes that entry back only when one of those bits changed.

The walker takes one request at a time through a valid/ready pair and returns a one-cycle response pulse. It reaches memory through a single request/response port that can stall. A probe request walks down to a chosen level and returns the raw entry found there. A probe never changes memory. When translation is disabled, the address passes straight through and no memory access is made.

Top module: `tbl_walker`

## Requirements
- R1: With `cfg_enable` low, a non-probe request responds in the cycle after acceptance with `resp_paddr` equal to the zero-extended virtual address, `resp_perm` = 3, `resp_fault` = 0, and no memory access.
- R2: The first read of a walk is at byte address (`cfg_ctx_base` << 4) + (`cfg_ctx_id` << 4), modulo 2^32.
- R3: Entry bits [1:0] give the type: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. A table pointer at level L leads to address ((entry with bits [1:0] cleared) << 4) + 4×index. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: A page entry at level 1 gives `resp_paddr` = (entry[31:8] << 12) + VA[23:0].
- R5: A page entry at level 2 gives `resp_paddr` = (entry[31:8] << 12) + VA[17:0].
- R6: A page entry at level 3 gives `resp_paddr` = (entry[31:8] << 12) + VA[11:0]. `resp_perm` is entry[4:2] at any level.
- R7: A fault returns `resp_fault` = (level << 8) | (type << 2), with zero `resp_paddr` and `resp_perm`. The level is 0 for the root entry. The type is 1 for an invalid entry and 4 for a reserved entry, a page entry at the root or a table pointer at level 3.
- R8: On a successful walk, bit 5 (referenced) is set, and bit 6 (modified) is also set for a write. The entry is written back to the address it came from only if a bit changed. `resp_entry` returns the updated entry.
- R9: With a memory that never stalls, the response comes R+W clock edges after acceptance. R is the number of entries read and W is 1 if a writeback happened, else 0.
- R10: While `mem_req` is high and `mem_rdy` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R11: A probe with `req_probe_lvl` = T returns in `resp_entry` the entry at level T, or an earlier valid page entry. It returns 0 if the walk meets an invalid, reserved or misplaced entry. A probe never writes memory, and its `resp_fault` and `resp_paddr` are 0.
- R12: `req_ready` is low from acceptance until the response, and `resp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_ctx_base | input | 32 | Context table pointer |
| cfg_ctx_id | input | CTX_W | Context number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_probe | input | 1 | Probe instead of translate |
| req_probe_lvl | input | 2 | Probe target level 0..3 |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | PA_W | Physical address |
| resp_perm | output | 3 | Permission field |
| resp_fault | output | 12 | Fault code, 0 on success |
| resp_entry | output | 32 | Final or probed entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a writeback |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Writeback data |
| mem_rdy | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` |

## Verification
The response comes a fixed number of edges after acceptance. A bypass takes no extra edges. A zero-wait walk takes one edge per entry read plus one for a writeback, and each memory stall adds one edge to the access it delays. The bench counts edges from the accepting edge and samples every result on the falling edge. It compares that count with the latency computed from the expected level and writeback decision, so a result that is early, late or missing is reported. Memory contents and write counts are read from the bench's own memory model after each response.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int ENT_W   = 32;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_RSVD    = 3'd4;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_TABLE   = 2'd1,
        ET_PAGE    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WBACK,
        S_RESP
    } wstate_e;

    function automatic logic [11:0] fault_code(input logic [1:0] lvl, input logic [2:0] ft);
        return {2'b00, lvl, 3'b000, ft, 2'b00};
    endfunction

endpackage

// File: rtl/walk_addr.sv
module walk_addr
    import walk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [31:0]      ctx_base,
    input  logic [CTX_W-1:0] ctx_id,
    input  logic [1:0]       lvl,
    input  logic [ENT_W-1:0] ent,
    input  logic [31:0]      va,
    output logic [31:0]      root_addr,
    output logic [31:0]      next_addr
);
    logic [7:0] idx;

    always_comb begin
        root_addr = (ctx_base << 4) + (32'(ctx_id) << 4);
        // index of the level below the entry just read
        case (lvl)
            2'd0:    idx = va[31:24];
            2'd1:    idx = {2'b00, va[23:18]};
            default: idx = {2'b00, va[17:12]};
        endcase
        next_addr = {ent[27:2], 6'b000000} + 32'({idx, 2'b00});
    end

endmodule

// File: rtl/walk_decode.sv
module walk_decode
    import walk_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [ENT_W-1:0] ent,
    input  logic [1:0]       lvl,
    input  logic [31:0]      va,
    input  logic             wr,
    output logic [11:0]      fault,
    output logic             is_page,
    output logic             is_table,
    output logic [PA_W-1:0]  pa,
    output logic [2:0]       perm,
    output logic [ENT_W-1:0] upd,
    output logic             need_wb
);
    ent_type_e   etype;
    logic [23:0] off;

    always_comb begin
        etype    = ent_type_e'(ent[1:0]);
        fault    = '0;
        is_page  = 1'b0;
        is_table = 1'b0;
        case (etype)
            ET_INVALID: fault = fault_code(lvl, FT_INVALID);
            ET_RSVD:    fault = fault_code(lvl, FT_RSVD);
            ET_PAGE: begin
                if (lvl == 2'd0) fault = fault_code(lvl, FT_RSVD);
                else             is_page = 1'b1;
            end
            default: begin
                if (lvl == 2'd3) fault = fault_code(lvl, FT_RSVD);
                else             is_table = 1'b1;
            end
        endcase

        case (lvl)
            2'd1:    off = va[23:0];
            2'd2:    off = {6'b0, va[17:0]};
            default: off = {12'b0, va[11:0]};
        endcase
        pa   = PA_W'({ent[31:8], 12'h000}) + PA_W'(off);
        perm = ent[4:2];

        upd = ent;
        upd[REF_BIT] = 1'b1;
        if (wr) upd[MOD_BIT] = 1'b1;
        need_wb = (upd != ent);
    end

endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
    import walk_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [31:0]      cfg_ctx_base,
    input  logic [CTX_W-1:0] cfg_ctx_id,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_probe,
    input  logic [1:0]       req_probe_lvl,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [2:0]       resp_perm,
    output logic [11:0]      resp_fault,
    output logic [31:0]      resp_entry,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_rdy,
    input  logic [31:0]      mem_rdata
);
    typedef struct packed {
        wstate_e          st;
        logic [1:0]       lvl;
        logic [31:0]      addr;
        logic [ENT_W-1:0] ent;
        logic [31:0]      va;
        logic             wr;
        logic             probe;
        logic [1:0]       plvl;
        logic [PA_W-1:0]  pa;
        logic [2:0]       perm;
        logic [11:0]      flt;
        logic [ENT_W-1:0] rent;
    } walk_reg_t;

    walk_reg_t r_q, r_d;

    logic [31:0]      root_addr, next_addr;
    logic [11:0]      dec_fault;
    logic             dec_page, dec_table, dec_wb;
    logic [PA_W-1:0]  dec_pa;
    logic [2:0]       dec_perm;
    logic [ENT_W-1:0] dec_upd;

    walk_addr #(.CTX_W(CTX_W)) u_addr (
        .ctx_base (cfg_ctx_base),
        .ctx_id   (cfg_ctx_id),
        .lvl      (r_q.lvl),
        .ent      (mem_rdata),
        .va       (r_q.va),
        .root_addr(root_addr),
        .next_addr(next_addr)
    );

    walk_decode #(.PA_W(PA_W)) u_dec (
        .ent     (mem_rdata),
        .lvl     (r_q.lvl),
        .va      (r_q.va),
        .wr      (r_q.wr),
        .fault   (dec_fault),
        .is_page (dec_page),
        .is_table(dec_table),
        .pa      (dec_pa),
        .perm    (dec_perm),
        .upd     (dec_upd),
        .need_wb (dec_wb)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_vaddr;
                    r_d.wr    = req_write;
                    r_d.probe = req_probe;
                    r_d.plvl  = req_probe_lvl;
                    r_d.lvl   = 2'd0;
                    r_d.pa    = '0;
                    r_d.perm  = '0;
                    r_d.flt   = '0;
                    r_d.rent  = '0;
                    if (!cfg_enable && !req_probe) begin
                        r_d.pa   = PA_W'(req_vaddr);
                        r_d.perm = 3'd3;
                        r_d.st   = S_RESP;
                    end else begin
                        r_d.addr = root_addr;
                        r_d.st   = S_READ;
                    end
                end
            end
            S_READ: begin
                if (mem_rdy) begin
                    if (r_q.probe) begin
                        if (dec_fault != '0) begin
                            r_d.rent = '0;
                            r_d.st   = S_RESP;
                        end else if (r_q.lvl == r_q.plvl || dec_page) begin
                            r_d.rent = mem_rdata;
                            r_d.st   = S_RESP;
                        end else begin
                            r_d.addr = next_addr;
                            r_d.lvl  = r_q.lvl + 2'd1;
                        end
                    end else if (dec_fault != '0) begin
                        r_d.flt = dec_fault;
                        r_d.st  = S_RESP;
                    end else if (dec_page) begin
                        r_d.pa   = dec_pa;
                        r_d.perm = dec_perm;
                        r_d.rent = dec_upd;
                        r_d.ent  = dec_upd;
                        r_d.st   = dec_wb ? S_WBACK : S_RESP;
                    end else if (dec_table) begin
                        r_d.addr = next_addr;
                        r_d.lvl  = r_q.lvl + 2'd1;
                    end
                end
            end
            S_WBACK: begin
                if (mem_rdy) r_d.st = S_RESP;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == S_IDLE);
    assign resp_valid = (r_q.st == S_RESP);
    assign resp_paddr = r_q.pa;
    assign resp_perm  = r_q.perm;
    assign resp_fault = r_q.flt;
    assign resp_entry = r_q.rent;
    assign mem_req    = (r_q.st == S_READ) || (r_q.st == S_WBACK);
    assign mem_we     = (r_q.st == S_WBACK);
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.ent;

endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_vaddr,
    input logic             req_probe,
    input logic             resp_valid,
    input logic [PA_W-1:0]  resp_paddr,
    input logic [2:0]       resp_perm,
    input logic [11:0]      resp_fault,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_rdy
);
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !cfg_enable && !req_probe |=>
            resp_valid && resp_paddr == PA_W'($past(req_vaddr)) && resp_fault == 12'h000 && !mem_req);

    a_r8_ref_written: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);

    a_r7_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault != 12'h000 |-> resp_paddr == '0 && resp_perm == 3'd0);

endmodule

bind tbl_walker walk_chk #(.CTX_W(CTX_W), .PA_W(PA_W)) u_walk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_enable(cfg_enable),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_probe (req_probe),
    .resp_valid(resp_valid),
    .resp_paddr(resp_paddr),
    .resp_perm (resp_perm),
    .resp_fault(resp_fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdy   (mem_rdy)
);

// File: tb/tbl_walker_bench.sv
`timescale 1ns/1ps
module tbl_walker_bench;
    localparam int CTX_W = 8;
    localparam int PA_W  = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             cfg_enable = 1'b1;
    logic [31:0]      cfg_ctx_base = 32'h10;
    logic [CTX_W-1:0] cfg_ctx_id = 8'd2;
    logic             req_valid = 1'b0, req_write = 1'b0, req_probe = 1'b0;
    logic [31:0]      req_vaddr = '0;
    logic [1:0]       req_probe_lvl = '0;
    logic             req_ready, resp_valid, mem_req, mem_we, mem_rdy;
    logic [PA_W-1:0]  resp_paddr;
    logic [2:0]       resp_perm;
    logic [11:0]      resp_fault;
    logic [31:0]      resp_entry, mem_addr, mem_wdata, mem_rdata;

    tbl_walker #(.CTX_W(CTX_W), .PA_W(PA_W)) u_tbl_walker (.*);

    // memory model
    logic [31:0] mem [0:1023];
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;
    int          stall_n = 0;
    int          wait_cnt = 0;
    int          wr_cnt = 0, acc_cnt = 0;

    always_comb begin
        mem_rdy   = mem_req && (wait_cnt >= stall_n);
        mem_rdata = (mem_addr < 32'h1000) ? mem[mem_addr[11:2]] : 32'h0;
    end

    always @(posedge clk) begin
        if (host_we) mem[host_addr[11:2]] <= host_data;
        if (mem_req && mem_rdy && mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && mem_rdy) acc_cnt <= acc_cnt + 1;
        wait_cnt <= (mem_req && !mem_rdy) ? wait_cnt + 1 : 0;
    end

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    logic [PA_W-1:0] o_pa;
    logic [2:0]      o_perm;
    logic [11:0]     o_flt;
    logic [31:0]     o_ent;
    int              o_lat;
    bit              o_ready_seen;

    task automatic run(input logic [31:0] va, input bit wr, input bit pr, input logic [1:0] pl);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_probe = pr; req_probe_lvl = pl;
        @(posedge clk);
        #1 req_valid = 1'b0;
        o_lat = 0;
        o_ready_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (resp_valid) break;
            if (req_ready) o_ready_seen = 1'b1;
            o_lat++;
            if (o_lat > 2000) begin
                chk("R12 response timeout", 64'(o_lat), 64'd0);
                break;
            end
        end
        o_pa = resp_paddr; o_perm = resp_perm; o_flt = resp_fault; o_ent = resp_entry;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // table layout: root 0x120 -> L1 0x400, L1[2] -> L2 0x800, L2[6] -> L3 0xC00
    localparam logic [31:0] PTE_A1 = 32'h404, PTE_A2 = 32'h814, PTE_A3 = 32'hC24;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset ready", 64'(req_ready), 64'd1);
        chk("R12 reset resp_valid", 64'(resp_valid), 64'd0);
        chk("R10 reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        poke(32'h120, 32'h41);
        poke(32'h408, 32'h81);
        poke(32'h410, 32'h3);
        poke(32'h818, 32'hC1);
        poke(32'h820, 32'h3);
        poke(32'hC28, 32'h101);
        poke(32'hC30, 32'h3);
        poke(32'h150, 32'h00ABCD12);
        poke(32'h170, 32'h3);

        // R1 bypass
        begin
            int a0;
            cfg_enable = 1'b0;
            a0 = acc_cnt;
            run(32'hDEADBEEF, 1'b1, 1'b0, 2'd0);
            chk("R1 bypass paddr", 64'(o_pa), 64'h0DEADBEEF);
            chk("R1 bypass perm", 64'(o_perm), 64'd3);
            chk("R1 bypass fault", 64'(o_flt), 64'd0);
            chk("R1 bypass latency", 64'(o_lat), 64'd0);
            chk("R1 bypass no access", 64'(acc_cnt - a0), 64'd0);
            cfg_enable = 1'b1;
        end

        // sweep of page levels, initial R/M state and access kind (R4 R5 R6 R8 R9)
        for (int lv = 1; lv <= 3; lv++) begin
            for (int rm = 0; rm < 4; rm++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [23:0] ppn;
                    logic [2:0]  pm;
                    logic [31:0] base, init, fin, va, pa_addr;
                    logic [23:0] off;
                    logic [PA_W-1:0] exp_pa;
                    bit wb;
                    int w0;
                    ppn = 24'h123400 + 24'(lv * 16 + rm * 2 + w);
                    pm  = 3'((lv + rm + w) % 8);
                    base = {ppn, 8'h00} | (32'(pm) << 2) | 32'h2;
                    init = base | (32'(rm) << 5);
                    case (lv)
                        1: begin
                            off = 24'h5AC30F + 24'(rm * 4369 + w);
                            va = {8'h01, off};
                            pa_addr = PTE_A1;
                        end
                        2: begin
                            off = {6'b0, 18'h2C0F5 ^ 18'(rm * 977 + w)};
                            va = {8'h02, 6'd5, off[17:0]};
                            pa_addr = PTE_A2;
                        end
                        default: begin
                            off = {12'b0, 12'hFED ^ 12'(rm * 33 + w)};
                            va = {8'h02, 6'd6, 6'd9, off[11:0]};
                            pa_addr = PTE_A3;
                        end
                    endcase
                    exp_pa = PA_W'({ppn, 12'h000}) + PA_W'(off);
                    wb  = ((rm & 1) == 0) || (w == 1 && (rm & 2) == 0);
                    fin = init | 32'h20 | (w != 0 ? 32'h40 : 32'h0);
                    poke(pa_addr, init);
                    w0 = wr_cnt;
                    run(va, w[0], 1'b0, 2'd0);
                    if (lv == 1) chk("R4 paddr 16MB", 64'(o_pa), 64'(exp_pa));
                    else if (lv == 2) chk("R5 paddr 256KB", 64'(o_pa), 64'(exp_pa));
                    else chk("R6 paddr 4KB", 64'(o_pa), 64'(exp_pa));
                    chk("R6 perm field", 64'(o_perm), 64'(pm));
                    chk("R7 no fault", 64'(o_flt), 64'd0);
                    chk("R9 latency", 64'(o_lat), 64'(lv + 1 + (wb ? 1 : 0)));
                    chk("R8 writes", 64'(wr_cnt - w0), 64'(wb ? 1 : 0));
                    chk("R8 stored entry", 64'(mem[pa_addr[11:2]]), 64'(fin));
                    chk("R8 resp entry", 64'(o_ent), 64'(fin));
                end
            end
        end

        // R7 faults: virtual address, context, expected code, reads
        begin
            logic [31:0] fva [10];
            logic [7:0]  fctx [10];
            logic [11:0] fexp [10];
            int          frd [10];
            fva[0] = {8'h03, 24'h0};                 fctx[0] = 8'd2; fexp[0] = 12'h104; frd[0] = 2;
            fva[1] = {8'h04, 24'h0};                 fctx[1] = 8'd2; fexp[1] = 12'h110; frd[1] = 2;
            fva[2] = {8'h02, 6'd7, 18'h0};           fctx[2] = 8'd2; fexp[2] = 12'h204; frd[2] = 3;
            fva[3] = {8'h02, 6'd8, 18'h0};           fctx[3] = 8'd2; fexp[3] = 12'h210; frd[3] = 3;
            fva[4] = {8'h02, 6'd6, 6'd10, 12'h0};    fctx[4] = 8'd2; fexp[4] = 12'h310; frd[4] = 4;
            fva[5] = {8'h02, 6'd6, 6'd11, 12'h0};    fctx[5] = 8'd2; fexp[5] = 12'h304; frd[5] = 4;
            fva[6] = {8'h02, 6'd6, 6'd12, 12'h0};    fctx[6] = 8'd2; fexp[6] = 12'h310; frd[6] = 4;
            fva[7] = 32'h01000000;                   fctx[7] = 8'd5; fexp[7] = 12'h010; frd[7] = 1;
            fva[8] = 32'h01000000;                   fctx[8] = 8'd6; fexp[8] = 12'h004; frd[8] = 1;
            fva[9] = 32'h01000000;                   fctx[9] = 8'd7; fexp[9] = 12'h010; frd[9] = 1;
            for (int k = 0; k < 10; k++) begin
                int w0;
                cfg_ctx_id = fctx[k];
                w0 = wr_cnt;
                run(fva[k], 1'b1, 1'b0, 2'd0);
                chk("R7 fault code", 64'(o_flt), 64'(fexp[k]));
                chk("R7 fault paddr", 64'(o_pa), 64'd0);
                chk("R9 fault latency", 64'(o_lat), 64'(frd[k]));
                chk("R8 no write on fault", 64'(wr_cnt - w0), 64'd0);
            end
            cfg_ctx_id = 8'd2;
        end

        // R11 probes (R2 root address, R3 table addressing)
        begin
            logic [31:0] leaf3;
            logic [31:0] va3;
            int w0;
            leaf3 = 32'h00777716;
            poke(PTE_A3, leaf3);
            va3 = {8'h02, 6'd6, 6'd9, 12'h123};
            w0 = wr_cnt;
            run(va3, 1'b1, 1'b1, 2'd0);
            chk("R2 probe root entry", 64'(o_ent), 64'h41);
            chk("R11 probe lat0", 64'(o_lat), 64'd1);
            run(va3, 1'b1, 1'b1, 2'd1);
            chk("R3 probe level1 entry", 64'(o_ent), 64'h81);
            run(va3, 1'b1, 1'b1, 2'd2);
            chk("R3 probe level2 entry", 64'(o_ent), 64'hC1);
            chk("R11 probe lat2", 64'(o_lat), 64'd3);
            run(va3, 1'b1, 1'b1, 2'd3);
            chk("R11 probe leaf entry", 64'(o_ent), 64'(leaf3));
            chk("R11 probe fault", 64'(o_flt), 64'd0);
            chk("R11 probe paddr", 64'(o_pa), 64'd0);
            chk("R11 probe no writes", 64'(wr_cnt - w0), 64'd0);
            chk("R11 probe leaves bits", 64'(mem[PTE_A3[11:2]]), 64'(leaf3));
            run({8'h01, 24'h0}, 1'b0, 1'b1, 2'd3);
            chk("R11 early page", 64'(o_ent), 64'(mem[PTE_A1[11:2]]));
            chk("R11 early page lat", 64'(o_lat), 64'd2);
            run({8'h03, 24'h0}, 1'b0, 1'b1, 2'd3);
            chk("R11 invalid gives zero", 64'(o_ent), 64'd0);
            run({8'h02, 6'd6, 6'd10, 12'h0}, 1'b0, 1'b1, 2'd3);
            chk("R11 level3 pointer gives zero", 64'(o_ent), 64'd0);
        end

        // R10 R12 stalled memory
        begin
            logic [31:0] leaf;
            leaf = 32'h00345612;
            poke(PTE_A3, leaf);
            stall_n = 3;
            run({8'h02, 6'd6, 6'd9, 12'hABC}, 1'b1, 1'b0, 2'd0);
            chk("R10 stalled paddr", 64'(o_pa), 64'h003456ABC);
            chk("R10 stalled latency", 64'(o_lat), 64'd20);
            chk("R12 busy while walking", 64'(o_ready_seen), 64'd0);
            chk("R8 stalled writeback", 64'(mem[PTE_A3[11:2]]), 64'(leaf | 32'h60));
            @(negedge clk);
            chk("R12 single pulse", 64'(resp_valid), 64'd0);
            stall_n = 0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule